// File: doc/BRIEF.md
# Page-mode DRAM access sequencer

This block sits between a simple host request port and an asynchronous DRAM with a multiplexed address bus, separate upper and lower write strobes, an output enable and a 16-bit data bus. The data bus is carried as three plain ports: a value to drive, a drive enable for the pad and a value sampled from the pad. The host presents a row/column address, a read or write flag, two byte enables and write data. For each access it accepts, the block returns exactly one completion pulse, and for reads that pulse carries the data. Every DRAM timing is a parameter counted in clock cycles.

The sequencer is a single state machine. From reset it sits in IDLE with RAS high and the bank precharged. An accepted request moves it to ROW_STROBE (RAS low, row address held for T_RCD cycles). It then enters COL_SETUP (column address driven for one cycle with CAS still high; for writes, the strobes and data go out here), then COL_STROBE (CAS low for T_CAS cycles; a read samples the bus at the end), then COL_PRECHG (CAS high for T_CP cycles while the completion pulse is shown). The machine then parks in ROW_OPEN with RAS still low. In ROW_OPEN, a new request to the same row with enough page budget left goes straight back to COL_SETUP. A request to another row, or one that arrives after the budget is spent, is held while the row closes through ROW_PRECHG (RAS high for T_RP cycles). ROW_PRECHG then leads to ROW_STROBE. If the budget runs out with no request waiting, the row closes and the machine returns to IDLE. Writes are always issued as early writes, with both strobes falling in the same cycle and before CAS falls.

Top module: `dram_page_seq`

## Requirements
- R1: After reset, RAS, CAS, OE and both write strobes are high (inactive), the data drive enable is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The row address `req_addr[17:9]` is on `dram_addr` when RAS falls. The column address `req_addr[8:0]` is on `dram_addr` when CAS falls.
- R3: CAS falls no sooner than T_RCD cycles after RAS falls. RAS stays high at least T_RP cycles between low periods, and each low period lasts at least T_RAS_MIN cycles.
- R4: A read holds CAS low for T_CAS cycles and samples the bus in the last of them. `rsp_valid` is then high for one cycle, and `rsp_rdata` carries the stored word.
- R5: A write is an early write. Strobe `dram_uwe_n` follows `req_be[1]` (bits 15:8) and `dram_lwe_n` follows `req_be[0]` (bits 7:0). The enabled strobes fall together while CAS is high, before CAS falls, and the write data is driven with them.
- R6: OE is low only during the column phases of a read. The data drive enable is never high while OE is low, and is high only while at least one write strobe is low.
- R7: A same-row request accepted while the row is open and the budget allows another page cycle is served without a new RAS fall.
- R8: A request to a different row closes the open row, precharges it and opens the new row with a new RAS fall.
- R9: RAS is never held low longer than PAGE_MAX cycles. A same-row request that would overrun the budget reopens the row. An open row with no request closes by itself once the budget is spent.
- R10: A request is taken only while `req_ready` is high. `req_ready` is low in the cycle after acceptance, and each accepted access produces exactly one single-cycle `rsp_valid` pulse.
- R11: A write with `req_be` = 00 lowers no strobe and leaves memory unchanged, yet still completes with one `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_addr | input | 18 | Row in bits 17:9, column in bits 8:0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables: bit 1 upper, bit 0 lower |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_valid` on reads |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_uwe_n | output | 1 | Upper byte write strobe, active low |
| dram_lwe_n | output | 1 | Lower byte write strobe, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Value for the data pad to drive |
| dram_dq_en | output | 1 | Data pad drive enable |
| dram_dq_in | input | 16 | Value sampled from the data pad |

## Verification
The bench builds the sequencer with T_RCD=2, T_CAS=4, T_CP=1, T_RP=5 and T_RAS_MIN=8, and shrinks PAGE_MAX to 40 cycles. The shorter budget lets one open row serve exactly five back-to-back accesses before it must close, so budget expiry, forced reopen and idle close all happen within a few dozen cycles. Under this configuration the bench sweeps every column from 0 to 15 in rows 0 to 3, for writes with rotating byte enables and then for reads. It also runs row-alternating patterns and a full-width address, and computes from the parameters how many RAS falls each pattern must cost.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROW_STROBE,
        S_COL_SETUP,
        S_COL_STROBE,
        S_COL_PRECHG,
        S_ROW_OPEN,
        S_ROW_PRECHG
    } seq_state_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/dram_seq_budget.sv
module dram_seq_budget #(
    parameter int PAGE_MAX  = 10000,
    parameter int PAGE_CYC  = 7,
    parameter int T_RAS_MIN = 8,
    parameter int T_RP      = 5,
    parameter int BW        = $clog2(PAGE_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_low,
    output logic [BW-1:0] low_cnt,
    output logic          page_room,
    output logic          ras_min_ok
);

    localparam int HW = $clog2(T_RP + 1);

    logic [BW-1:0] cnt_q;
    logic [HW-1:0] hcnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!ras_low) begin
            cnt_q <= '0;
        end else if (cnt_q != BW'(PAGE_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt_q <= HW'(T_RP);
        end else if (ras_low) begin
            hcnt_q <= '0;
        end else if (hcnt_q != HW'(T_RP)) begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end

    assign low_cnt    = cnt_q;
    assign page_room  = (int'(cnt_q) + PAGE_CYC) < PAGE_MAX;
    assign ras_min_ok = (int'(cnt_q) + 1) >= T_RAS_MIN;

    AST_RAS_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low |-> (int'(cnt_q) < PAGE_MAX)); // R9

    AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_low) |-> (int'(hcnt_q) >= T_RP)); // R3

    AST_RAS_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_low) |-> (int'($past(cnt_q)) + 1 >= T_RAS_MIN)); // R3

endmodule

// File: rtl/dram_seq_row.sv
module dram_seq_row #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          clear,
    input  logic [AW-1:0] row_in,
    input  logic [AW-1:0] cmp_row,
    output logic          hit
);

    logic [AW-1:0] open_q;
    logic          valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= '0;
            valid_q <= 1'b0;
        end else if (clear) begin
            valid_q <= 1'b0;
        end else if (capture) begin
            open_q  <= row_in;
            valid_q <= 1'b1;
        end
    end

    assign hit = valid_q && (cmp_row == open_q);

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
    import dram_seq_pkg::*;
#(
    parameter int AW        = 9,
    parameter int DW        = 16,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 4,
    parameter int T_CP      = 1,
    parameter int T_RP      = 5,
    parameter int T_RAS_MIN = 8,
    parameter int PAGE_MAX  = 10000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [2*AW-1:0] req_addr,
    input  logic            req_write,
    input  logic [1:0]      req_be,
    input  logic [DW-1:0]   req_wdata,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_rdata,
    output logic            dram_ras_n,
    output logic            dram_cas_n,
    output logic            dram_oe_n,
    output logic            dram_uwe_n,
    output logic            dram_lwe_n,
    output logic [AW-1:0]   dram_addr,
    output logic [DW-1:0]   dram_dq_out,
    output logic            dram_dq_en,
    input  logic [DW-1:0]   dram_dq_in
);

    localparam int PAGE_CYC = T_CAS + T_CP + 2;
    localparam int TMAX     = max4(T_RCD, T_CAS, T_CP, T_RP);
    localparam int TW       = $clog2(TMAX + 1);
    localparam int BW       = $clog2(PAGE_MAX + 1);

    seq_state_t    state_q, state_d;
    logic          pend_q, pend_d;
    logic [AW-1:0] row_q, col_q;
    logic          wr_q;
    logic [1:0]    be_q;
    logic [DW-1:0] wd_q;
    logic [DW-1:0] rd_q;
    logic          rsp_q;

    logic          accept;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          row_hit, page_room, ras_min_ok;
    logic          ras_low;
    logic [BW-1:0] ras_cnt;
    logic          col_phase;
    logic          last_cas;

    assign accept   = req_valid && req_ready;
    assign last_cas = (state_q == S_COL_STROBE) && tmr_zero;

    dram_seq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    dram_seq_budget #(
        .PAGE_MAX  (PAGE_MAX),
        .PAGE_CYC  (PAGE_CYC),
        .T_RAS_MIN (T_RAS_MIN),
        .T_RP      (T_RP),
        .BW        (BW)
    ) u_budget (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_low    (ras_low),
        .low_cnt    (ras_cnt),
        .page_room  (page_room),
        .ras_min_ok (ras_min_ok)
    );

    dram_seq_row #(.AW(AW)) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (state_q == S_ROW_STROBE),
        .clear   ((state_q == S_ROW_PRECHG) || (state_q == S_IDLE)),
        .row_in  (row_q),
        .cmp_row (req_addr[2*AW-1:AW]),
        .hit     (row_hit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // Request latch and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
            wr_q  <= 1'b0;
            be_q  <= '0;
            wd_q  <= '0;
            rd_q  <= '0;
            rsp_q <= 1'b0;
        end else begin
            if (accept) begin
                row_q <= req_addr[2*AW-1:AW];
                col_q <= req_addr[AW-1:0];
                wr_q  <= req_write;
                be_q  <= req_be;
                wd_q  <= req_wdata;
            end
            if (last_cas && !wr_q) begin
                rd_q <= dram_dq_in;
            end
            rsp_q <= last_cas;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) state_d = S_ROW_STROBE;
            end
            S_ROW_STROBE: begin
                if (tmr_zero) state_d = S_COL_SETUP;
            end
            S_COL_SETUP: begin
                state_d = S_COL_STROBE;
            end
            S_COL_STROBE: begin
                if (tmr_zero) state_d = S_COL_PRECHG;
            end
            S_COL_PRECHG: begin
                if (tmr_zero) state_d = S_ROW_OPEN;
            end
            S_ROW_OPEN: begin
                if (pend_q) begin
                    if (ras_min_ok) state_d = S_ROW_PRECHG;
                end else if (accept) begin
                    if (row_hit && page_room) begin
                        state_d = S_COL_SETUP;
                    end else begin
                        pend_d = 1'b1;
                        if (ras_min_ok) state_d = S_ROW_PRECHG;
                    end
                end else if (!page_room) begin
                    state_d = S_ROW_PRECHG;
                end
            end
            S_ROW_PRECHG: begin
                if (tmr_zero) begin
                    state_d = pend_q ? S_ROW_STROBE : S_IDLE;
                    pend_d  = 1'b0;
                end
            end
            default: begin
                state_d = S_IDLE;
                pend_d  = 1'b0;
            end
        endcase
    end

    // Timer load on every state change
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            S_ROW_STROBE: tmr_val = TW'(T_RCD - 1);
            S_COL_STROBE: tmr_val = TW'(T_CAS - 1);
            S_COL_PRECHG: tmr_val = TW'(T_CP - 1);
            S_ROW_PRECHG: tmr_val = TW'(T_RP - 1);
            default:      tmr_val = '0;
        endcase
    end

    // Output decode
    always_comb begin
        ras_low   = (state_q == S_ROW_STROBE) || (state_q == S_COL_SETUP) ||
                    (state_q == S_COL_STROBE) || (state_q == S_COL_PRECHG) ||
                    (state_q == S_ROW_OPEN);
        col_phase = (state_q == S_COL_SETUP) || (state_q == S_COL_STROBE);

        dram_ras_n  = !ras_low;
        dram_cas_n  = (state_q != S_COL_STROBE);
        dram_addr   = (state_q == S_IDLE || state_q == S_ROW_STROBE ||
                       state_q == S_ROW_PRECHG) ? row_q : col_q;
        dram_oe_n   = !(col_phase && !wr_q);
        dram_uwe_n  = !(col_phase && wr_q && be_q[1]);
        dram_lwe_n  = !(col_phase && wr_q && be_q[0]);
        dram_dq_en  = col_phase && wr_q && (be_q != 2'b00);
        dram_dq_out = wd_q;

        req_ready = ((state_q == S_IDLE) || (state_q == S_ROW_OPEN)) && !pend_q;
        rsp_valid = rsp_q;
        rsp_rdata = rd_q;
    end

    AST_CAS_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> (int'(ras_cnt) >= T_RCD)); // R3

    AST_STROBE_BEFORE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_uwe_n) || $fell(dram_lwe_n)) |-> dram_cas_n); // R5

    AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_uwe_n) && !dram_lwe_n) |-> $fell(dram_lwe_n)); // R5

    AST_DRIVE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_en |-> (!dram_uwe_n || !dram_lwe_n)); // R6

    AST_OE_NOT_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> (!dram_dq_en && !dram_ras_n)); // R6

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10

    AST_BUSY_AT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R10

endmodule

// File: tb/sim_dram_page_seq.sv
module sim_dram_page_seq;

    localparam int AW = 9, DW = 16;
    localparam int TRCD = 2, TCAS = 4, TCP = 1, TRP = 5, TRASMIN = 8, PMAX = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [2*AW-1:0] req_addr = '0;
    logic            req_write = 1'b0;
    logic [1:0]      req_be = 2'b00;
    logic [DW-1:0]   req_wdata = '0;
    logic            rsp_valid;
    logic [DW-1:0]   rsp_rdata;
    logic            dram_ras_n, dram_cas_n, dram_oe_n, dram_uwe_n, dram_lwe_n;
    logic [AW-1:0]   dram_addr;
    logic [DW-1:0]   dram_dq_out;
    logic            dram_dq_en;
    logic [DW-1:0]   dram_dq_in;

    dram_page_seq #(
        .AW(AW), .DW(DW), .T_RCD(TRCD), .T_CAS(TCAS), .T_CP(TCP),
        .T_RP(TRP), .T_RAS_MIN(TRASMIN), .PAGE_MAX(PMAX)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_oe_n(dram_oe_n),
        .dram_uwe_n(dram_uwe_n), .dram_lwe_n(dram_lwe_n), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_en(dram_dq_en), .dram_dq_in(dram_dq_in)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // DRAM model state
    logic [15:0] mem    [0:255];
    logic [15:0] shadow [0:255];
    logic [8:0]  cap_row = '0;
    logic [8:0]  cap_col = '0;
    int ras_falls = 0, we_falls = 0, rsp_count = 0;
    int low_run = 0, high_run = TRP;
    int viol_rp = 0, viol_rcd = 0, viol_rasmin = 0, viol_len = 0;
    int viol_oe = 0, viol_dq = 0, viol_we = 0;
    int accepted = 0, busy_viol = 0;
    logic p_ras = 1'b1, p_cas = 1'b1, p_uwe = 1'b1, p_lwe = 1'b1;

    assign dram_dq_in = (!dram_oe_n && !dram_cas_n) ? mem[{cap_row[3:0], cap_col[3:0]}] : 16'hBAD0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pin-level model and protocol monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !dram_ras_n) begin
                ras_falls++;
                if (high_run < TRP) viol_rp++;
                cap_row = dram_addr;
                low_run = 0;
            end
            if (!p_ras && dram_ras_n && low_run < TRASMIN) viol_rasmin++;
            if (!dram_ras_n) begin
                low_run++;
                high_run = 0;
                if (low_run > PMAX) viol_len++;
            end else begin
                high_run++;
            end
            if (p_cas && !dram_cas_n) begin
                if (low_run - 1 < TRCD) viol_rcd++;
                cap_col = dram_addr;
                if ((!dram_uwe_n && p_uwe) || (!dram_lwe_n && p_lwe)) viol_we++;
                if ((!dram_uwe_n || !dram_lwe_n) && !dram_dq_en) viol_dq++;
                if (!dram_uwe_n) mem[{cap_row[3:0], dram_addr[3:0]}][15:8] = dram_dq_out[15:8];
                if (!dram_lwe_n) mem[{cap_row[3:0], dram_addr[3:0]}][7:0]  = dram_dq_out[7:0];
            end
            if ((p_uwe && !dram_uwe_n) || (p_lwe && !dram_lwe_n)) begin
                we_falls++;
                if (!dram_cas_n) viol_we++;
                if (!dram_uwe_n && !dram_lwe_n && ((p_uwe && !dram_uwe_n) != (p_lwe && !dram_lwe_n)))
                    viol_we++;
            end
            if (!dram_oe_n && dram_dq_en) viol_oe++;
            if (!dram_oe_n && dram_ras_n) viol_oe++;
            if (dram_dq_en && dram_uwe_n && dram_lwe_n) viol_dq++;
            if (rsp_valid) rsp_count++;
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
            p_uwe = dram_uwe_n;
            p_lwe = dram_lwe_n;
        end
    end

    task automatic access(input bit wr, input logic [8:0] r, input logic [8:0] c,
                          input logic [1:0] be, input logic [15:0] d, output logic [15:0] q);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {r, c};
        req_be    = be;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        accepted++;
        if (req_ready) busy_viol++;
        while (!rsp_valid) @(negedge clk);
        q = rsp_rdata;
        if (wr) begin
            if (be[1]) shadow[{r[3:0], c[3:0]}][15:8] = d[15:8];
            if (be[0]) shadow[{r[3:0], c[3:0]}][7:0]  = d[7:0];
        end
    endtask

    task automatic settle();
        repeat (60) @(negedge clk);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] q, old;
        int per_row, cpos, f0, wf0, bad_addr, bad_data;
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 16'(i * 16'h0123 + 16'h0F0F);
            shadow[i] = 16'(i * 16'h0123 + 16'h0F0F);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(dram_ras_n && dram_cas_n && dram_oe_n && dram_uwe_n && dram_lwe_n &&
            !dram_dq_en && req_ready && !rsp_valid, "R1 reset pins",
            {dram_ras_n, dram_cas_n, dram_oe_n, dram_uwe_n, dram_lwe_n, dram_dq_en, req_ready, rsp_valid},
            8'b11111010);

        // R5 / R2: write sweep, rows 0..3, columns 0..15
        bad_addr = 0;
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 16; c++) begin
                logic [1:0] be;
                be = (c % 4 == 1) ? 2'b10 : (c % 4 == 2) ? 2'b01 : 2'b11;
                access(1'b1, 9'(r), 9'(c), be, 16'((r * 4096) ^ (c * 257) ^ 16'h5A3C), q);
                if (cap_row != 9'(r) || cap_col != 9'(c)) bad_addr++;
            end
        end
        chk(bad_addr == 0, "R2 write address phases", bad_addr, 0);

        // R4: read sweep
        bad_data = 0;
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 16; c++) begin
                access(1'b0, 9'(r), 9'(c), 2'b11, 16'h0, q);
                if (cap_row != 9'(r) || cap_col != 9'(c)) bad_addr++;
                if (q !== shadow[{4'(r), 4'(c)}]) begin
                    bad_data++;
                    chk(1'b0, "R4 read data", int'(q), int'(shadow[{4'(r), 4'(c)}]));
                end
            end
        end
        chk(bad_addr == 0, "R2 read address phases", bad_addr, 0);
        chk(bad_data == 0, "R5 byte-lane writes seen by reads", bad_data, 0);

        // R9: open row closes by itself
        settle();
        chk(dram_ras_n == 1'b1, "R9 idle close", dram_ras_n, 1);

        // Accesses that fit in one open row, from the parameters
        per_row = 1;
        cpos = TRCD + TCAS + TCP + 1;
        while (cpos + (TCAS + TCP + 2) < PMAX) begin
            per_row++;
            cpos += TCAS + TCP + 2;
        end

        // R7: same-row burst of per_row accesses, one RAS fall
        f0 = ras_falls;
        for (int k = 0; k < per_row; k++) access(1'b0, 9'd2, 9'(k), 2'b11, 16'h0, q);
        chk(ras_falls - f0 == 1, "R7 page hits one RAS", ras_falls - f0, 1);
        // R9: one more same-row access exceeds the budget and reopens
        access(1'b0, 9'd2, 9'd9, 2'b11, 16'h0, q);
        chk(ras_falls - f0 == 2, "R9 budget reopen", ras_falls - f0, 2);
        chk(q === shadow[{4'd2, 4'd9}], "R4 read after reopen", int'(q), int'(shadow[{4'd2, 4'd9}]));

        // R8: alternating rows
        settle();
        f0 = ras_falls;
        access(1'b0, 9'd1, 9'd4, 2'b11, 16'h0, q);
        access(1'b0, 9'd3, 9'd4, 2'b11, 16'h0, q);
        chk(q === shadow[{4'd3, 4'd4}], "R8 data after row change", int'(q), int'(shadow[{4'd3, 4'd4}]));
        access(1'b0, 9'd1, 9'd5, 2'b11, 16'h0, q);
        chk(ras_falls - f0 == 3, "R8 row miss reopens", ras_falls - f0, 3);

        // R11: empty byte enable write
        settle();
        old = shadow[{4'd1, 4'd3}];
        wf0 = we_falls;
        access(1'b1, 9'd1, 9'd3, 2'b00, 16'hFFFF, q);
        chk(we_falls == wf0, "R11 no strobe", we_falls - wf0, 0);
        access(1'b0, 9'd1, 9'd3, 2'b11, 16'h0, q);
        chk(q === old, "R11 memory unchanged", int'(q), int'(old));

        // R2: full-width address
        settle();
        access(1'b1, 9'h1F5, 9'h1AA, 2'b11, 16'hC3E1, q);
        access(1'b0, 9'h1F5, 9'h1AA, 2'b11, 16'h0, q);
        chk(cap_row == 9'h1F5, "R2 full row", int'(cap_row), 'h1F5);
        chk(cap_col == 9'h1AA, "R2 full column", int'(cap_col), 'h1AA);
        chk(q === 16'hC3E1, "R4 full-width read", int'(q), 'hC3E1);

        settle();
        chk(viol_rp == 0, "R3 precharge time", viol_rp, 0);
        chk(viol_rcd == 0, "R3 RAS to CAS delay", viol_rcd, 0);
        chk(viol_rasmin == 0, "R3 RAS pulse min", viol_rasmin, 0);
        chk(viol_we == 0, "R5 early write strobes", viol_we, 0);
        chk(viol_oe == 0, "R6 OE exclusivity", viol_oe, 0);
        chk(viol_dq == 0, "R6 drive with strobe", viol_dq, 0);
        chk(viol_len == 0, "R9 RAS low bound", viol_len, 0);
        chk(rsp_count == accepted, "R10 one completion each", rsp_count, accepted);
        chk(busy_viol == 0, "R10 busy after accept", busy_viol, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule